// File: doc/BRIEF.md
# Masked Event Register Bank

This block gathers seventeen level-sensitive event lines into a sticky status word and presents a single interrupt request to a processor. Software reaches it through a 32-bit word-access slave bus with APB-style setup and access phases. A mask word decides which status bits reach the interrupt output. Software cannot write the mask directly. It clears mask bits through an enable port and sets them through a disable port. A trigger port lets software raise any implemented status bit itself.

Event line 0 is the global-fault source: while it is high, the two global-fault status bits are set. Lines 1 to 16 are context sources: while any of them is high, the two combined-context status bits are set. The performance bit and the decode-error bit have no input line and are set only through the trigger port. Beside the event logic, the bank holds seven plain configuration words. Each has its own reset value and its own set of writable bits.

A small bus-phase state machine qualifies every access. `PH_IDLE` moves to `PH_SETUP` on select without enable. `PH_SETUP` moves to `PH_ACCESS` on select with enable, which commits the access, or returns to `PH_IDLE` on deselect. `PH_ACCESS` returns to `PH_SETUP` on a new setup, drops to `PH_IDLE` on deselect, and otherwise stays put without committing again.

Top module: `masked_event_bank`

## Requirements
- R1: After reset, the registers read as follows: status 0x00000000, mask 0x8000001F, power-request word (0x40) 0x00007FFF, misc word (0x54) 0x00000016, spare-1 word (0x108) 0xFFFFFFFF. Every other mapped word reads 0, and `irq_out` is low.
- R2: At offset 0x10, writing 1 to a status bit in 0x8000001F clears that bit and writing 0 leaves it unchanged. Bits 30:5 always read 0.
- R3: The mask word at 0x14 is read-only. A bus write to 0x14 leaves it unchanged.
- R4: A 1 in a write to the enable port (0x18) clears the matching mask bit. A 1 in a write to the disable port (0x1C) sets it. Both ports read 0.
- R5: A 1 in a write to the trigger port (0x20) sets the matching status bit within 0x8000001F. The port reads 0.
- R6: When event line 0 is high at a clock edge, status bits 4 and 3 are 1 after that edge. When any of lines 1..16 is high, status bits 1 and 0 are 1. No line sets bit 2 or bit 31.
- R7: Status bits are sticky. If a clear and an input-driven set hit the same bit in one cycle, the bit stays 1.
- R8: `irq_out` is high exactly when some status bit is 1 while its mask bit is 0. It follows register changes with no extra cycle.
- R9: The writable bits of each configuration word are: misc-control (0x00) all 32; power-request (0x40) bits 14:0; misc (0x54) bits 12 and 7:1, with bits 11:8 reading 0; config-signals (0x58) bit 1; revision (0x100), spare-0 (0x104) and spare-1 (0x108) all 32. Writes leave all other bits unchanged.
- R10: A read from an unmapped or non-word-aligned offset returns 0. A write to such an offset changes no register.
- R11: A write whose byte strobe `pstrb` is not 4'b1111 changes no register.
- R12: An access is committed only in an enable cycle that directly follows a setup cycle. An enable phase without a preceding setup phase commits nothing, and a held enable commits once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access-phase enable |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | ADDR_W (12) | Byte address |
| pwdata | input | 32 | Write data |
| pstrb | input | 4 | Byte strobes; only 4'b1111 writes |
| prdata | output | 32 | Read data, valid in the committing access cycle |
| pready | output | 1 | High in every access cycle (no wait states) |
| irq_src | input | NUM_SRC (17) | Level-sensitive event lines |
| irq_out | output | 1 | Combined masked interrupt request |

## Verification
The status word is driven in three ways: by software triggers with every source masked, which separates status setting from interrupt generation; by event line 0 alone and by the top context line alone, which shows that each source sets its own bit pair and no other bit; and by a full clear issued while a source stays high, which shows that a set beats a clear. The mask is moved one bit at a time through the enable and disable ports, so that `irq_out` is seen to follow exactly one unmasked pending bit. Malformed bus traffic, namely partial strobes, unmapped offsets and an enable phase with no setup phase, is followed by a read-back of the word it might have disturbed.

// File: rtl/meb_pkg.sv
`timescale 1ns/1ps
package meb_pkg;
    localparam int          DW        = 32;
    localparam logic [31:0] EVT_VALID = 32'h8000_001F;

    // status bit positions
    localparam int EVT_CTX_NS = 0;
    localparam int EVT_CTX_S  = 1;
    localparam int EVT_PERF   = 2;
    localparam int EVT_GF_S   = 3;
    localparam int EVT_GF_NS  = 4;
    localparam int EVT_DECERR = 31;

    // event-block byte offsets
    localparam logic [11:0] OFF_STAT = 12'h010;
    localparam logic [11:0] OFF_MASK = 12'h014;
    localparam logic [11:0] OFF_EN   = 12'h018;
    localparam logic [11:0] OFF_DIS  = 12'h01C;
    localparam logic [11:0] OFF_TRIG = 12'h020;

    localparam int NUM_CFG = 7;

    typedef enum logic [1:0] {PH_IDLE, PH_SETUP, PH_ACCESS} bus_phase_t;

    function automatic logic [11:0] cfg_offset(input int i);
        case (i)
            0:       return 12'h000;
            1:       return 12'h040;
            2:       return 12'h054;
            3:       return 12'h058;
            4:       return 12'h100;
            5:       return 12'h104;
            default: return 12'h108;
        endcase
    endfunction

    function automatic logic [31:0] cfg_reset(input int i);
        case (i)
            1:       return 32'h0000_7FFF;
            2:       return 32'h0000_0016;
            6:       return 32'hFFFF_FFFF;
            default: return 32'h0000_0000;
        endcase
    endfunction

    function automatic logic [31:0] cfg_wmask(input int i);
        case (i)
            1:       return 32'h0000_7FFF;
            2:       return 32'h0000_10FE;
            3:       return 32'h0000_0002;
            default: return 32'hFFFF_FFFF;
        endcase
    endfunction
endpackage

// File: rtl/meb_bus_fsm.sv
`timescale 1ns/1ps
module meb_bus_fsm
    import meb_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       psel,
    input  logic       penable,
    input  logic       pwrite,
    input  logic [3:0] pstrb,
    output logic       wr_stb,
    output logic       rd_stb,
    output logic       pready
);
    bus_phase_t state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= PH_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PH_IDLE: begin
                if (psel && !penable) state_d = PH_SETUP;
            end
            PH_SETUP: begin
                if (psel && penable) state_d = PH_ACCESS;
                else if (!psel)      state_d = PH_IDLE;
            end
            PH_ACCESS: begin
                if (psel && !penable) state_d = PH_SETUP;
                else if (!psel)       state_d = PH_IDLE;
            end
            default: state_d = PH_IDLE;
        endcase
    end

    logic commit;
    always_comb begin
        commit = (state_q == PH_SETUP) && psel && penable;
        wr_stb = commit && pwrite && (pstrb == 4'hF);
        rd_stb = commit && !pwrite;
        pready = psel && penable;
    end

    // R12: a committed access is never repeated in the following cycle
    assert_one_commit_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb || rd_stb) |=> !(wr_stb || rd_stb));
endmodule

// File: rtl/meb_event_core.sv
`timescale 1ns/1ps
module meb_event_core
    import meb_pkg::*;
#(
    parameter int NUM_SRC = 17
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src,
    input  logic               stat_wr,
    input  logic               en_wr,
    input  logic               dis_wr,
    input  logic               trig_wr,
    input  logic [DW-1:0]      wdata,
    output logic [DW-1:0]      status,
    output logic [DW-1:0]      mask,
    output logic               irq_out
);
    logic [DW-1:0] status_q, status_d, mask_q, mask_d, set_v, clr_v, wbits;
    logic          glob, ctx;

    always_comb begin
        wbits = wdata & EVT_VALID;
        glob  = src[0];
        ctx   = |src[NUM_SRC-1:1];
        set_v = '0;
        set_v[EVT_GF_S]   = glob;
        set_v[EVT_GF_NS]  = glob;
        set_v[EVT_CTX_NS] = ctx;
        set_v[EVT_CTX_S]  = ctx;
        if (trig_wr) set_v = set_v | wbits;
        clr_v    = stat_wr ? wbits : '0;
        status_d = (status_q & ~clr_v) | set_v;   // set beats clear
        mask_d   = mask_q;
        if (en_wr)  mask_d = mask_d & ~wbits;
        if (dis_wr) mask_d = mask_d | wbits;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status_q <= '0;
            mask_q   <= EVT_VALID;
        end else begin
            status_q <= status_d;
            mask_q   <= mask_d;
        end
    end

    assign status  = status_q;
    assign mask    = mask_q;
    assign irq_out = |(status_q & ~mask_q);

    assert_glob_sets_R6: assert property (@(posedge clk) disable iff (!rst_n)
        src[0] |=> (status[EVT_GF_NS] && status[EVT_GF_S]));
    assert_set_beats_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((|src[NUM_SRC-1:1]) && stat_wr) |=> (status[EVT_CTX_S] && status[EVT_CTX_NS]));
    assert_mask_only_ports_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(en_wr || dis_wr) |=> $stable(mask));
    assert_all_masked_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mask == EVT_VALID) |-> !irq_out);
    assert_perf_no_input_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!trig_wr && !status[EVT_PERF]) |=> !status[EVT_PERF]);
endmodule

// File: rtl/meb_cfg_bank.sv
`timescale 1ns/1ps
module meb_cfg_bank
    import meb_pkg::*;
#(
    parameter int WA_W = 10
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_stb,
    input  logic [WA_W-1:0] waddr,
    input  logic [DW-1:0]   wdata,
    output logic [DW-1:0]   rdata,
    output logic            hit
);
    logic [NUM_CFG-1:0][DW-1:0] regs_q;
    logic [NUM_CFG-1:0][DW-1:0] rd_v;
    logic [NUM_CFG-1:0]         hit_v;

    for (genvar g = 0; g < NUM_CFG; g++) begin : g_cfg
        localparam logic [WA_W-1:0] OFFW = WA_W'(cfg_offset(g) >> 2);
        localparam logic [DW-1:0]   RSTV = cfg_reset(g);
        localparam logic [DW-1:0]   WMSK = cfg_wmask(g);

        assign hit_v[g] = (waddr == OFFW);
        assign rd_v[g]  = hit_v[g] ? regs_q[g] : '0;

        always_ff @(posedge clk) begin
            if (!rst_n)
                regs_q[g] <= RSTV;
            else if (wr_stb && hit_v[g])
                regs_q[g] <= (regs_q[g] & ~WMSK) | (wdata & WMSK);
        end
    end

    always_comb begin
        rdata = '0;
        for (int i = 0; i < NUM_CFG; i++) rdata = rdata | rd_v[i];
        hit = |hit_v;
    end

    assert_cfg_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_stb |=> $stable(regs_q));
endmodule

// File: rtl/masked_event_bank.sv
`timescale 1ns/1ps
module masked_event_bank
    import meb_pkg::*;
#(
    parameter int ADDR_W  = 12,
    parameter int NUM_SRC = 17
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               psel,
    input  logic               penable,
    input  logic               pwrite,
    input  logic [ADDR_W-1:0]  paddr,
    input  logic [31:0]        pwdata,
    input  logic [3:0]         pstrb,
    output logic [31:0]        prdata,
    output logic               pready,
    input  logic [NUM_SRC-1:0] irq_src,
    output logic               irq_out
);
    localparam int WA_W = ADDR_W - 2;
    localparam logic [WA_W-1:0] W_STAT = WA_W'(OFF_STAT >> 2);
    localparam logic [WA_W-1:0] W_MASK = WA_W'(OFF_MASK >> 2);
    localparam logic [WA_W-1:0] W_EN   = WA_W'(OFF_EN >> 2);
    localparam logic [WA_W-1:0] W_DIS  = WA_W'(OFF_DIS >> 2);
    localparam logic [WA_W-1:0] W_TRIG = WA_W'(OFF_TRIG >> 2);

    logic            wr_stb, rd_stb, aligned, wr_ok;
    logic [WA_W-1:0] waddr;
    logic [31:0]     status, mask, cfg_rdata;
    logic            cfg_hit, evt_hit, mapped;

    assign waddr   = paddr[ADDR_W-1:2];
    assign aligned = (paddr[1:0] == 2'b00);
    assign wr_ok   = wr_stb && aligned;
    assign evt_hit = (waddr == W_STAT) || (waddr == W_MASK) || (waddr == W_EN) ||
                     (waddr == W_DIS) || (waddr == W_TRIG);
    assign mapped  = aligned && (evt_hit || cfg_hit);

    meb_bus_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable),
        .pwrite(pwrite), .pstrb(pstrb),
        .wr_stb(wr_stb), .rd_stb(rd_stb), .pready(pready)
    );

    meb_event_core #(.NUM_SRC(NUM_SRC)) u_evt (
        .clk(clk), .rst_n(rst_n), .src(irq_src),
        .stat_wr(wr_ok && waddr == W_STAT),
        .en_wr  (wr_ok && waddr == W_EN),
        .dis_wr (wr_ok && waddr == W_DIS),
        .trig_wr(wr_ok && waddr == W_TRIG),
        .wdata(pwdata), .status(status), .mask(mask), .irq_out(irq_out)
    );

    meb_cfg_bank #(.WA_W(WA_W)) u_cfg (
        .clk(clk), .rst_n(rst_n), .wr_stb(wr_ok), .waddr(waddr),
        .wdata(pwdata), .rdata(cfg_rdata), .hit(cfg_hit)
    );

    always_comb begin
        prdata = '0;
        if (rd_stb && aligned) begin
            if (waddr == W_STAT)      prdata = status;
            else if (waddr == W_MASK) prdata = mask;
            else if (cfg_hit)         prdata = cfg_rdata;
        end
    end

    assert_unmapped_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && !mapped) |-> (prdata == 32'h0));
endmodule

// File: tb/masked_event_bank_test.sv
`timescale 1ns/1ps
module masked_event_bank_test;
    logic        clk = 0, rst_n = 0;
    logic        psel = 0, penable = 0, pwrite = 0;
    logic [11:0] paddr = '0;
    logic [31:0] pwdata = '0;
    logic [3:0]  pstrb = 4'hF;
    logic [31:0] prdata;
    logic        pready, irq_out;
    logic [16:0] irq_src = '0;

    int total = 0, bad = 0;

    typedef struct { logic [31:0] v; string req; } exp_t;
    exp_t sb[$];

    always #2 clk = ~clk;

    masked_event_bank uut (
        .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .pstrb(pstrb), .prdata(prdata),
        .pready(pready), .irq_src(irq_src), .irq_out(irq_out)
    );

    // monitor: compares read data in the middle of each access cycle
    always @(negedge clk) begin
        if (psel && penable && !pwrite && sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            total++;
            if (prdata !== e.v) begin
                bad++;
                $display("FAIL %s: read got %h expected %h", e.req, prdata, e.v);
            end
        end
    end

    task automatic chk_irq(input logic exp, input string req);
        total++;
        if (irq_out !== exp) begin
            bad++;
            $display("FAIL %s: irq_out got %b expected %b", req, irq_out, exp);
        end
    endtask

    task automatic bus_wr(input logic [11:0] a, input logic [31:0] d,
                          input logic [3:0] s = 4'hF);
        psel = 1; penable = 0; pwrite = 1; paddr = a; pwdata = d; pstrb = s;
        @(posedge clk); #1 penable = 1;
        @(posedge clk); #1 psel = 0; penable = 0; pstrb = 4'hF;
    endtask

    task automatic bus_wr_nosetup(input logic [11:0] a, input logic [31:0] d);
        psel = 1; penable = 1; pwrite = 1; paddr = a; pwdata = d;
        @(posedge clk); #1 psel = 0; penable = 0;
    endtask

    task automatic bus_rd(input logic [11:0] a, input logic [31:0] e, input string req);
        exp_t x;
        x.v = e; x.req = req;
        sb.push_back(x);
        psel = 1; penable = 0; pwrite = 0; paddr = a;
        @(posedge clk); #1 penable = 1;
        @(posedge clk); #1 psel = 0; penable = 0;
    endtask

    task automatic tick();
        @(posedge clk); #1;
    endtask

    initial begin
        #400000;
        bad++; total++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        tick();
        // R1 reset values
        chk_irq(1'b0, "R1");
        bus_rd(12'h000, 32'h0, "R1");
        bus_rd(12'h010, 32'h0, "R1");
        bus_rd(12'h014, 32'h8000001F, "R1");
        bus_rd(12'h040, 32'h00007FFF, "R1");
        bus_rd(12'h054, 32'h00000016, "R1");
        bus_rd(12'h058, 32'h0, "R1");
        bus_rd(12'h100, 32'h0, "R1");
        bus_rd(12'h108, 32'hFFFFFFFF, "R1");
        // R9 writable bits
        bus_wr(12'h000, 32'hFFFFFFFF); bus_rd(12'h000, 32'hFFFFFFFF, "R9");
        bus_wr(12'h040, 32'hFFFFFFFF); bus_rd(12'h040, 32'h00007FFF, "R9");
        bus_wr(12'h054, 32'hFFFFFFFF); bus_rd(12'h054, 32'h000010FE, "R9");
        bus_wr(12'h054, 32'h0);        bus_rd(12'h054, 32'h0, "R9");
        bus_wr(12'h058, 32'hFFFFFFFF); bus_rd(12'h058, 32'h00000002, "R9");
        bus_wr(12'h104, 32'hFFFFFFFF); bus_rd(12'h104, 32'hFFFFFFFF, "R9");
        // R3 mask read-only
        bus_wr(12'h014, 32'h0); bus_rd(12'h014, 32'h8000001F, "R3");
        // R5 trigger, all masked
        bus_wr(12'h020, 32'h80000004); bus_rd(12'h010, 32'h80000004, "R5");
        chk_irq(1'b0, "R8");
        bus_rd(12'h020, 32'h0, "R5");
        bus_wr(12'h020, 32'hFFFFFFFF); bus_rd(12'h010, 32'h8000001F, "R5");
        // R4 enable/disable
        bus_wr(12'h018, 32'h4); bus_rd(12'h014, 32'h8000001B, "R4");
        chk_irq(1'b1, "R8");
        bus_rd(12'h018, 32'h0, "R4");
        bus_rd(12'h01C, 32'h0, "R4");
        // R2 write-1-to-clear
        bus_wr(12'h010, 32'h4); bus_rd(12'h010, 32'h8000001B, "R2");
        chk_irq(1'b0, "R8");
        bus_wr(12'h010, 32'h0); bus_rd(12'h010, 32'h8000001B, "R2");
        bus_wr(12'h010, 32'hFFFFFFFF); bus_rd(12'h010, 32'h0, "R2");
        bus_wr(12'h01C, 32'h4); bus_rd(12'h014, 32'h8000001F, "R4");
        bus_wr(12'h018, 32'h8000001F); bus_rd(12'h014, 32'h0, "R4");
        chk_irq(1'b0, "R8");
        // R6 / R7 event lines
        irq_src = 17'h00001; tick();
        chk_irq(1'b1, "R8");
        bus_rd(12'h010, 32'h00000018, "R6");
        bus_wr(12'h010, 32'hFFFFFFFF); bus_rd(12'h010, 32'h00000018, "R7");
        irq_src = '0; bus_wr(12'h010, 32'hFFFFFFFF);
        bus_rd(12'h010, 32'h0, "R7");
        chk_irq(1'b0, "R8");
        irq_src = 17'h10000; tick();
        bus_rd(12'h010, 32'h00000003, "R6");
        chk_irq(1'b1, "R6");
        irq_src = 17'h00020; bus_wr(12'h010, 32'hFFFFFFFF);
        bus_rd(12'h010, 32'h00000003, "R7");
        irq_src = '0; bus_wr(12'h010, 32'hFFFFFFFF);
        chk_irq(1'b0, "R8");
        // R10 unmapped / unaligned
        bus_wr(12'h030, 32'hFFFFFFFF); bus_rd(12'h030, 32'h0, "R10");
        bus_wr(12'h106, 32'h0);        bus_rd(12'h104, 32'hFFFFFFFF, "R10");
        bus_rd(12'h102, 32'h0, "R10");
        // R11 partial strobe
        bus_wr(12'h104, 32'h0, 4'h3);  bus_rd(12'h104, 32'hFFFFFFFF, "R11");
        // R12 enable without setup
        bus_wr_nosetup(12'h104, 32'h0); bus_rd(12'h104, 32'hFFFFFFFF, "R12");
        bus_wr(12'h104, 32'h0);         bus_rd(12'h104, 32'h0, "R12");
        tick();
        if (sb.size() != 0) begin
            bad++; total++;
            $display("FAIL scoreboard: got %0d pending expected 0", sb.size());
        end
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule